// File: doc/BRIEF.md
# Interrupt Error Status Latch

This block records error events for a local interrupt controller in two stages. Each error source delivers a one-cycle pulse on its own line, and each pulse sets a bit in a hidden accumulator. Software cannot see the accumulator. Software reads a separate visible status register instead. Any write to that register loads it from the accumulator and empties the accumulator in the same cycle. The value written is discarded. Software can therefore take a coherent snapshot of all errors since the last snapshot without losing any event that arrives meanwhile.

Beside the status register the block holds an error vector entry. The entry has a mask bit, an 8-bit vector and a delivery-status flag. When new errors arrive and the entry is unmasked, the block raises an interrupt request and marks the entry pending. The entry stays pending until the downstream logic acknowledges the request. A build-time parameter selects when a request is raised. In one setting any error bit that is not already held triggers a request. In the other setting only the first error into an empty accumulator triggers one.

Top module: `err_status_latch`

## Requirements
- R1: An error pulse on `err_evt[i]` sets bit i of the hidden accumulator. The bit stays set until the next status write.
- R2: A write to the status address (0) loads the visible status with the accumulator contents and clears the accumulator. The write data has no effect on either register.
- R3: The visible status changes only on a status write.
- R4: An error pulse in the same cycle as a status write lands in the newly cleared accumulator. It is absent from that snapshot and appears in the next one.
- R5: Error bit meanings, bit 7 down to bit 0: bad register address, bad vector received, bad vector sent, redirectable broadcast, receive accept error, send accept error, receive checksum error, send checksum error.
- R6: A read of the status address returns the status in bits 7:0 and zeros in bits 31:8. A read of any unused address returns zero.
- R7: The entry at address 1 holds the vector in bits 7:0, delivery status in bit 12 (1 = pending) and the mask in bit 16. Software can write the vector and the mask. Bit 12 is read-only.
- R8: While the mask bit is 1, no interrupt request is raised. The accumulator still collects the errors.
- R9: With the any-new policy, a request is raised when a pulse carries a bit not already in the accumulator. A pulse in the same cycle as a status write is compared against an empty accumulator.
- R10: With the first-only policy, a request is raised only when the accumulator is empty before the pulse.
- R11: `irq_req` equals the pending flag. The flag sets one cycle after a triggering pulse and clears one cycle after `irq_ack`. A new trigger in the same cycle as an acknowledge keeps it set. `irq_vector` carries the entry vector.
- R12: After reset, the status and the accumulator are zero, the mask is 1, the vector is 0 and the entry is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt | input | 8 | One-cycle error pulses, one line per error bit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 status, 1 entry |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_ack | input | 1 | Downstream acceptance of the pending request |
| irq_req | output | 1 | Interrupt request, equal to the pending flag |
| irq_vector | output | 8 | Vector of the error entry |

## Verification
The assertions assume that each `err_evt` line is a clean synchronous pulse that never carries an unknown value. They also assume that `irq_ack` is meaningful only while a request is pending. Under those conditions, every change in pending state must trace back to an event, an acknowledge or the mask. The stimulus drives all inputs on the falling edge and returns them to zero after one cycle. It acknowledges only pending requests, except in one deliberate case where an acknowledge coincides with a new trigger. Two instances with opposite trigger policies receive identical stimulus, so the cases where the policies differ show up side by side.

// File: rtl/esl_pkg.sv
package esl_pkg;

    localparam int unsigned ERR_W  = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned VEC_W  = 8;

    localparam int unsigned ENT_DS_BIT   = 12;
    localparam int unsigned ENT_MASK_BIT = 16;

    // error bit positions
    localparam int unsigned ERR_TX_CSUM   = 0;
    localparam int unsigned ERR_RX_CSUM   = 1;
    localparam int unsigned ERR_TX_ACCEPT = 2;
    localparam int unsigned ERR_RX_ACCEPT = 3;
    localparam int unsigned ERR_REDIR_BC  = 4;
    localparam int unsigned ERR_TX_BADVEC = 5;
    localparam int unsigned ERR_RX_BADVEC = 6;
    localparam int unsigned ERR_BAD_REG   = 7;

    typedef enum logic {
        TRIG_ANY_NEW    = 1'b0,
        TRIG_FIRST_ONLY = 1'b1
    } trig_policy_e;

    typedef struct packed {
        logic             mask;
        logic             pending;
        logic [VEC_W-1:0] vector;
    } entry_t;

    function automatic logic [DATA_W-1:0] pack_entry(entry_t e);
        logic [DATA_W-1:0] r;
        r = '0;
        r[VEC_W-1:0]   = e.vector;
        r[ENT_DS_BIT]   = e.pending;
        r[ENT_MASK_BIT] = e.mask;
        return r;
    endfunction

    function automatic logic [ERR_W-1:0] fresh_bits(logic [ERR_W-1:0] base,
                                                    logic [ERR_W-1:0] evt);
        return evt & ~base;
    endfunction

endpackage

// File: rtl/esl_accum.sv
module esl_accum
    import esl_pkg::*;
#(
    parameter int unsigned W = ERR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         copy,
    output logic [W-1:0] hidden_q,
    output logic [W-1:0] status_q,
    output logic [W-1:0] base
);
    // accumulator as seen by this cycle's events (already cleared on copy)
    always_comb base = copy ? '0 : hidden_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hidden_q <= '0;
            status_q <= '0;
        end else begin
            hidden_q <= base | evt;
            if (copy) status_q <= hidden_q;
        end
    end
endmodule

// File: rtl/esl_trigger.sv
module esl_trigger
    import esl_pkg::*;
#(
    parameter int unsigned  W      = ERR_W,
    parameter trig_policy_e POLICY = TRIG_ANY_NEW
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] evt,
    output logic         fire
);
    generate
        if (POLICY == TRIG_ANY_NEW) begin : g_any
            always_comb fire = |fresh_bits(base, evt);
        end else begin : g_first
            always_comb fire = (base == '0) && (|evt);
        end
    endgenerate
endmodule

// File: rtl/esl_entry.sv
module esl_entry
    import esl_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          fire,
    input  logic          ack,
    output entry_t        entry_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q.mask    <= 1'b1;
            entry_q.pending <= 1'b0;
            entry_q.vector  <= '0;
        end else begin
            if (wr_en) begin
                entry_q.mask   <= wdata[ENT_MASK_BIT];
                entry_q.vector <= wdata[VEC_W-1:0];
            end
            if (fire && !entry_q.mask)
                entry_q.pending <= 1'b1;
            else if (ack)
                entry_q.pending <= 1'b0;
        end
    end
endmodule

// File: rtl/err_status_latch.sv
module err_status_latch
    import esl_pkg::*;
#(
    parameter int unsigned  ADDR_W      = 2,
    parameter int unsigned  STS_ADDR    = 0,
    parameter int unsigned  ENT_ADDR    = 1,
    parameter trig_policy_e TRIG_POLICY = TRIG_ANY_NEW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ERR_W-1:0]  err_evt,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector
);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STS_ADDR);
    localparam logic [ADDR_W-1:0] A_ENT = ADDR_W'(ENT_ADDR);

    logic             sts_wr, ent_wr, fire, mask_w;
    logic [ERR_W-1:0] hidden_q, status_q, base;
    entry_t           entry_q;

    always_comb begin
        sts_wr = bus_wr && (bus_addr == A_STS);
        ent_wr = bus_wr && (bus_addr == A_ENT);
    end

    esl_accum #(.W(ERR_W)) u_accum (
        .clk(clk), .rst(rst), .evt(err_evt), .copy(sts_wr),
        .hidden_q(hidden_q), .status_q(status_q), .base(base)
    );

    esl_trigger #(.W(ERR_W), .POLICY(TRIG_POLICY)) u_trig (
        .base(base), .evt(err_evt), .fire(fire)
    );

    esl_entry #(.DW(DATA_W)) u_entry (
        .clk(clk), .rst(rst), .wr_en(ent_wr), .wdata(bus_wdata),
        .fire(fire), .ack(irq_ack), .entry_q(entry_q)
    );

    always_comb begin
        mask_w     = entry_q.mask;
        irq_req    = entry_q.pending;
        irq_vector = entry_q.vector;
        if (bus_addr == A_STS)
            bus_rdata = {{(DATA_W-ERR_W){1'b0}}, status_q};
        else if (bus_addr == A_ENT)
            bus_rdata = pack_entry(entry_q);
        else
            bus_rdata = '0;
    end
endmodule

// File: rtl/esl_chk.sv
module esl_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] evt,
    input logic         sts_wr,
    input logic [W-1:0] hidden,
    input logic [W-1:0] status,
    input logic         mask,
    input logic         pending,
    input logic         ack
);
    // R2
    copy_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        sts_wr |=> status == $past(hidden));

    // R4
    clear_keeps_evt_chk: assert property (@(posedge clk) disable iff (rst)
        sts_wr |=> hidden == $past(evt));

    // R3
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sts_wr |=> $stable(status));

    // R1
    sticky_bits_chk: assert property (@(posedge clk) disable iff (rst)
        !sts_wr |=> (hidden & $past(hidden)) == $past(hidden));

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask && !pending) |=> !pending);

    // R11
    rise_needs_evt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(evt) != '0);

    // R11
    ack_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && ack && evt == '0) |=> !pending);
endmodule

bind err_status_latch esl_chk #(.W(esl_pkg::ERR_W)) u_chk (
    .clk(clk), .rst(rst), .evt(err_evt), .sts_wr(sts_wr),
    .hidden(hidden_q), .status(status_q), .mask(mask_w),
    .pending(irq_req), .ack(irq_ack)
);

// File: tb/tb_err_status_latch.sv
module tb_err_status_latch;
    import esl_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  err_evt = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        irq_ack = 1'b0;
    logic [31:0] rdata_a, rdata_f;
    logic        irq_a, irq_f;
    logic [7:0]  vec_a, vec_f;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    err_status_latch #(.TRIG_POLICY(TRIG_ANY_NEW)) dut (
        .clk(clk), .rst(rst), .err_evt(err_evt), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .irq_ack(irq_ack), .irq_req(irq_a), .irq_vector(vec_a)
    );

    err_status_latch #(.TRIG_POLICY(TRIG_FIRST_ONLY)) dut_first (
        .clk(clk), .rst(rst), .err_evt(err_evt), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_f),
        .irq_ack(irq_ack), .irq_req(irq_f), .irq_vector(vec_f)
    );

    typedef struct packed {
        logic [7:0] evt;
        logic       wr;
        logic       ack;
        logic [7:0] sts;
        logic       irq_any;
        logic       irq_first;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{8'h01, 1'b0, 1'b0, 8'h08, 1'b1, 1'b1},
        '{8'h00, 1'b0, 1'b1, 8'h08, 1'b0, 1'b0},
        '{8'h01, 1'b0, 1'b0, 8'h08, 1'b0, 1'b0},
        '{8'h80, 1'b0, 1'b0, 8'h08, 1'b1, 1'b0},
        '{8'h00, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0},
        '{8'h24, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1},
        '{8'h00, 1'b1, 1'b1, 8'h24, 1'b0, 1'b0},
        '{8'h10, 1'b0, 1'b1, 8'h24, 1'b1, 1'b1},
        '{8'h00, 1'b0, 1'b1, 8'h24, 1'b0, 1'b0}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle of stimulus, return inputs to idle, select read address
    task automatic apply(logic [7:0] evt, logic wr, logic [1:0] addr,
                         logic [31:0] wd, logic ack, logic [1:0] raddr);
        @(negedge clk);
        err_evt = evt; bus_wr = wr; bus_addr = addr; bus_wdata = wd; irq_ack = ack;
        @(negedge clk);
        err_evt = '0; bus_wr = 1'b0; irq_ack = 1'b0; bus_addr = raddr;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bus_addr = 2'd0;
        #1;
        // R12 reset state
        chk("R12 status after reset", rdata_a, 32'h0);
        chk("R12 irq after reset", {31'b0, irq_a}, 32'h0);
        bus_addr = 2'd1; #1;
        chk("R12 R7 entry after reset", rdata_a, 32'h0001_0000);
        bus_addr = 2'd2; #1;
        chk("R6 unused address", rdata_a, 32'h0);

        // R8 masked: error collected, no request
        apply(8'h08, 1'b0, 2'd0, 32'h0, 1'b0, 2'd1);
        chk("R8 masked any-new irq", {31'b0, irq_a}, 32'h0);
        chk("R8 masked first-only irq", {31'b0, irq_f}, 32'h0);
        chk("R8 R7 entry idle while masked", rdata_a, 32'h0001_0000);
        // R2 copy with all-ones data ignored; R5 bit 3 receive accept error
        apply(8'h00, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, 2'd0);
        chk("R2 R5 status copy ignores data", rdata_a, 32'h0000_0008);

        // R7 unmask, vector 0x42, attempt to set read-only bit 12
        apply(8'h00, 1'b1, 2'd1, 32'h0000_1042, 1'b0, 2'd1);
        chk("R7 entry write", rdata_a, 32'h0000_0042);
        chk("R7 irq_vector", {24'b0, vec_a}, 32'h0000_0042);

        // table: R1 R3 R4 R9 R10 R11
        foreach (TBL[i]) begin
            apply(TBL[i].evt, TBL[i].wr, 2'd0, 32'hA5A5_A5A5, TBL[i].ack, 2'd0);
            chk($sformatf("R1 R3 R4 status step %0d", i), rdata_a, {24'b0, TBL[i].sts});
            chk($sformatf("R4 first-only status step %0d", i), rdata_f, {24'b0, TBL[i].sts});
            chk($sformatf("R9 R11 any-new irq step %0d", i), {31'b0, irq_a}, {31'b0, TBL[i].irq_any});
            chk($sformatf("R10 R11 first-only irq step %0d", i), {31'b0, irq_f}, {31'b0, TBL[i].irq_first});
        end

        // R11 pending visible in entry bit 12; R10 no request with non-empty accumulator
        apply(8'h40, 1'b0, 2'd0, 32'h0, 1'b0, 2'd1);
        chk("R11 entry pending", rdata_a, 32'h0000_1042);
        chk("R10 first-only quiet", {31'b0, irq_f}, 32'h0);
        // R6 R5 snapshot of bits 6 and 4 with upper bits zero
        apply(8'h00, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b1, 2'd0);
        chk("R6 R5 status snapshot", rdata_a, 32'h0000_0050);
        chk("R11 ack clears", {31'b0, irq_a}, 32'h0);

        // R12 reset again restores mask
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; bus_addr = 2'd1; #1;
        chk("R12 entry after second reset", rdata_a, 32'h0001_0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule